// File: doc/BRIEF.md
# CPU exception entry controller

This block performs the architectural entry into an exception handler for a 32-bit processor core. Each cycle it looks at the pending exception causes and the external interrupt request, picks one winner, and produces everything the core needs to redirect execution. That is the handler address, a write to the correct link register holding the interrupted PC, and an updated interrupt-enable register.

Exceptions fall into two classes. The normal class covers bus errors, divide by zero, interrupt and system call. It saves the PC in the exception-address register, keeps the old enable in a saved-enable bit, and vectors off the normal base, or off the debug base when remapping is on. The debug class covers breakpoint and watchpoint. It has its own link register and saved-enable bit, and it always vectors off the debug base. A system call that a host-call hook reports as serviced is not entered at all; the PC simply moves past the call. All results are registered and appear one clock after the causes.

Top module: `exc_entry_ctrl`

## Requirements
- R1: A winning normal-class cause (number 2, 4, 5, 6, or 7 when not host-serviced) asserts `ea_we` with `ea_data` equal to `cur_pc`, and leaves `ba_we` low.
- R2: On normal-class entry, `ie_we` is asserted and `ie_data` has bit 1 (saved normal enable) equal to the old bit 0 (global enable), bit 0 cleared, and bit 2 unchanged.
- R3: The normal-class target PC is the base with its low 8 bits replaced by the exception number times 32. The base is `debug_base` when `remap` is 1, otherwise `norm_base`.
- R4: A winning breakpoint (1) or watchpoint (3) asserts `ba_we` with `ba_data` equal to `cur_pc`, and leaves `ea_we` low.
- R5: On debug-class entry, `ie_data` has bit 2 equal to the old bit 0, bit 0 cleared, and bit 1 unchanged. The target PC is `debug_base` (low 8 bits replaced) plus number times 32, regardless of `remap`.
- R6: The interrupt (number 6) is pending only when `irq_req` is 1 and `ie_cur` bit 0 is 1. Bits 0 and 6 of `cause_i` have no effect.
- R7: When system call (7) wins and `host_done` is 1, `pc_load` is asserted with `pc_next` equal to `cur_pc + 4`, and `ea_we`, `ba_we` and `ie_we` stay low.
- R8: When several causes are pending, the lowest exception number wins.
- R9: Outputs are registered with a latency of one cycle. With no pending cause, `pc_load`, `ea_we`, `ba_we` and `ie_we` are low in the following cycle and the data outputs hold.
- R10: During and right after reset, all strobes and data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_pc | input | 32 | PC of the instruction taking the exception |
| cause_i | input | 8 | Pending causes, bit k = exception number k |
| irq_req | input | 1 | External interrupt request |
| host_done | input | 1 | Host-call hook serviced the system call |
| ie_cur | input | 3 | Current enable register {saved debug, saved normal, global} |
| norm_base | input | 32 | Normal exception base |
| debug_base | input | 32 | Debug exception base |
| remap | input | 1 | Send normal exceptions to the debug base |
| pc_load | output | 1 | Load `pc_next` into the PC |
| pc_next | output | 32 | New PC |
| ea_we | output | 1 | Exception-address register write |
| ea_data | output | 32 | Value for the exception-address register |
| ba_we | output | 1 | Breakpoint-address register write |
| ba_data | output | 32 | Value for the breakpoint-address register |
| ie_we | output | 1 | Enable register write |
| ie_data | output | 3 | New enable register value |

## Verification
The hardest cases to reach are where several causes collide: an interrupt request arriving with the global enable clear alongside a higher-numbered system call, or a serviced system call masked by a lower-numbered fault. The stimulus first walks directed collisions of these kinds with `remap` in both states. It then runs a long stretch of sparse random cause patterns, in which the enable bits and the hook response vary every cycle. A behavioural model in the bench is compared with every output on each clock.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int NUM_EXC   = 8;
  localparam int EXC_W     = $clog2(NUM_EXC);
  localparam int SLOT_SH   = 5;  // 32 bytes per vector slot
  localparam int BASE_LSB  = EXC_W + SLOT_SH;
  localparam int IE_W      = 3;
  localparam int IE_GLB    = 0;
  localparam int IE_SAV_N  = 1;
  localparam int IE_SAV_D  = 2;

  typedef enum logic [EXC_W-1:0] {
    EXC_RESET = 3'd0,
    EXC_BRK   = 3'd1,
    EXC_IBUS  = 3'd2,
    EXC_WATCH = 3'd3,
    EXC_DBUS  = 3'd4,
    EXC_DIV0  = 3'd5,
    EXC_IRQ   = 3'd6,
    EXC_SCALL = 3'd7
  } exc_num_e;

  function automatic logic is_debug_class(exc_num_e n);
    return (n == EXC_BRK) || (n == EXC_WATCH);
  endfunction
endpackage

// File: rtl/exc_prio_pick.sv
module exc_prio_pick #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  pend,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (pend[k]) begin
        any = 1'b1;
        idx = IW'(k);
      end
    end
  end
endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen import exc_entry_pkg::*; #(
  parameter int PC_W = 32
) (
  input  logic [PC_W-1:0]  norm_base,
  input  logic [PC_W-1:0]  debug_base,
  input  logic             remap,
  input  logic             dbg,
  input  logic [EXC_W-1:0] num,
  output logic [PC_W-1:0]  vec
);
  logic [PC_W-1:0] base_sel;

  always_comb begin
    base_sel = (dbg || remap) ? debug_base : norm_base;
    vec      = {base_sel[PC_W-1:BASE_LSB], num, {SLOT_SH{1'b0}}};
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl import exc_entry_pkg::*; #(
  parameter int PC_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PC_W-1:0]     cur_pc,
  input  logic [NUM_EXC-1:0]  cause_i,
  input  logic                irq_req,
  input  logic                host_done,
  input  logic [IE_W-1:0]     ie_cur,
  input  logic [PC_W-1:0]     norm_base,
  input  logic [PC_W-1:0]     debug_base,
  input  logic                remap,
  output logic                pc_load,
  output logic [PC_W-1:0]     pc_next,
  output logic                ea_we,
  output logic [PC_W-1:0]     ea_data,
  output logic                ba_we,
  output logic [PC_W-1:0]     ba_data,
  output logic                ie_we,
  output logic [IE_W-1:0]     ie_data
);
  localparam logic [PC_W-1:0] STEP = PC_W'(4);

  logic [NUM_EXC-1:0] pend;
  logic               take;
  logic [EXC_W-1:0]   win_idx;
  exc_num_e           win;
  logic               dbg, host;
  logic [PC_W-1:0]    vec;

  // next-state signals
  logic               pc_load_d, ea_we_d, ba_we_d, ie_we_d;
  logic [PC_W-1:0]    pc_d;
  logic [IE_W-1:0]    ie_d;

  always_comb begin
    pend          = cause_i;
    pend[EXC_RESET] = 1'b0;
    pend[EXC_IRQ] = irq_req & ie_cur[IE_GLB];
  end

  exc_prio_pick #(.N(NUM_EXC)) u_pick (
    .pend (pend),
    .any  (take),
    .idx  (win_idx)
  );

  assign win  = exc_num_e'(win_idx);
  assign dbg  = take && is_debug_class(win);
  assign host = take && (win == EXC_SCALL) && host_done;

  exc_vector_gen #(.PC_W(PC_W)) u_vec (
    .norm_base  (norm_base),
    .debug_base (debug_base),
    .remap      (remap),
    .dbg        (dbg),
    .num        (win_idx),
    .vec        (vec)
  );

  always_comb begin
    pc_load_d = take;
    ea_we_d   = take && !dbg && !host;
    ba_we_d   = dbg;
    ie_we_d   = take && !host;
    pc_d      = host ? (cur_pc + STEP) : vec;
    ie_d      = ie_cur;
    ie_d[IE_GLB] = 1'b0;
    if (dbg) ie_d[IE_SAV_D] = ie_cur[IE_GLB];
    else     ie_d[IE_SAV_N] = ie_cur[IE_GLB];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_load <= 1'b0;
      ea_we   <= 1'b0;
      ba_we   <= 1'b0;
      ie_we   <= 1'b0;
      pc_next <= '0;
      ea_data <= '0;
      ba_data <= '0;
      ie_data <= '0;
    end else begin
      pc_load <= pc_load_d;
      ea_we   <= ea_we_d;
      ba_we   <= ba_we_d;
      ie_we   <= ie_we_d;
      if (pc_load_d) pc_next <= pc_d;
      if (ea_we_d)   ea_data <= cur_pc;
      if (ba_we_d)   ba_data <= cur_pc;
      if (ie_we_d)   ie_data <= ie_d;
    end
  end

  // assertions
  AST_ONE_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    !(ea_we && ba_we)); // R4
  AST_GLB_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    ie_we |-> !ie_data[IE_GLB]); // R2
  AST_VEC_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load && ie_we) |-> (pc_next[SLOT_SH-1:0] == '0)); // R3
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (((cause_i & 8'hBE) == '0) && !ie_cur[IE_GLB]) |=> !pc_load); // R6
  AST_HOST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load && !ie_we) |-> (!ea_we && !ba_we)); // R7
  AST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (((cause_i & 8'hBE) == '0) && !irq_req) |=> (!pc_load && !ie_we)); // R9
endmodule

// File: tb/exc_entry_ctrl_tb.sv
module exc_entry_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] cur_pc, norm_base, debug_base;
  logic [7:0]  cause_i;
  logic        irq_req, host_done, remap;
  logic [2:0]  ie_cur;
  logic        pc_load, ea_we, ba_we, ie_we;
  logic [31:0] pc_next, ea_data, ba_data;
  logic [2:0]  ie_data;

  int checks = 0;
  int errors = 0;

  // model state
  logic        m_load, m_ea_we, m_ba_we, m_ie_we;
  logic [31:0] m_pc, m_ea, m_ba;
  logic [2:0]  m_ie;

  always #5 clk = ~clk;

  exc_entry_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .cause_i(cause_i),
    .irq_req(irq_req), .host_done(host_done), .ie_cur(ie_cur),
    .norm_base(norm_base), .debug_base(debug_base), .remap(remap),
    .pc_load(pc_load), .pc_next(pc_next), .ea_we(ea_we), .ea_data(ea_data),
    .ba_we(ba_we), .ba_data(ba_data), .ie_we(ie_we), .ie_data(ie_data)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // behavioural reference: decide the winner by scanning numbers upward
  task automatic model_step();
    int win = -1;
    bit dbg;
    logic [31:0] base;
    for (int n = 1; n < 8; n++) begin
      bit p = (n == 6) ? (irq_req && ie_cur[0]) : cause_i[n];
      if (p && win < 0) win = n;
    end
    m_load = 0; m_ea_we = 0; m_ba_we = 0; m_ie_we = 0;
    if (win < 0) return;
    m_load = 1;
    if (win == 7 && host_done) begin
      m_pc = cur_pc + 32'd4;
      return;
    end
    dbg  = (win == 1) || (win == 3);
    base = (dbg || remap) ? debug_base : norm_base;
    m_pc = (base & 32'hFFFF_FF00) + 32'(win * 32);
    m_ie_we = 1;
    if (dbg) begin
      m_ba_we = 1; m_ba = cur_pc;
      m_ie = {ie_cur[0], ie_cur[1], 1'b0};
    end else begin
      m_ea_we = 1; m_ea = cur_pc;
      m_ie = {ie_cur[2], ie_cur[0], 1'b0};
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "pc_load", 32'(pc_load), 32'(m_load));
    chk(tag, "pc_next", pc_next, m_pc);
    chk(tag, "ea_we",   32'(ea_we), 32'(m_ea_we));
    chk(tag, "ea_data", ea_data, m_ea);
    chk(tag, "ba_we",   32'(ba_we), 32'(m_ba_we));
    chk(tag, "ba_data", ba_data, m_ba);
    chk(tag, "ie_we",   32'(ie_we), 32'(m_ie_we));
    chk(tag, "ie_data", 32'(ie_data), 32'(m_ie));
  endtask

  task automatic step(string tag, logic [7:0] c, logic irq, logic hd,
                      logic [2:0] ie, logic rm, logic [31:0] pc);
    cause_i = c; irq_req = irq; host_done = hd; ie_cur = ie; remap = rm; cur_pc = pc;
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; cause_i = 0; irq_req = 0; host_done = 0; ie_cur = 0; remap = 0;
    cur_pc = 0; norm_base = 32'h0000_4A37; debug_base = 32'hC000_21FF;
    m_load = 0; m_ea_we = 0; m_ba_we = 0; m_ie_we = 0;
    m_pc = 0; m_ea = 0; m_ba = 0; m_ie = 0;
    repeat (3) @(negedge clk);
    compare("R10 reset");
    rst_n = 1;
    @(negedge clk);
    compare("R10 after reset");

    step("R9 idle",            8'h00, 0, 0, 3'b001, 0, 32'h100);
    step("R1 R2 R3 ibus",      8'h04, 0, 0, 3'b101, 0, 32'h1004);
    step("R3 remap dbus",      8'h10, 0, 0, 3'b011, 1, 32'h2008);
    step("R3 div0",            8'h20, 0, 0, 3'b000, 0, 32'h200C);
    step("R4 R5 brk remap0",   8'h02, 0, 0, 3'b011, 0, 32'h3000);
    step("R5 watch remap1",    8'h08, 0, 0, 3'b101, 1, 32'h3010);
    step("R6 irq enabled",     8'h00, 1, 0, 3'b001, 0, 32'h4000);
    step("R6 irq masked",      8'h00, 1, 0, 3'b110, 0, 32'h4004);
    step("R6 cause bits 0 6",  8'h41, 0, 0, 3'b001, 0, 32'h4008);
    step("R6 R8 masked irq vs scall", 8'h80, 1, 0, 3'b000, 0, 32'h400C);
    step("R7 host serviced",   8'h80, 0, 1, 3'b001, 0, 32'h5000);
    step("R7 scall unserviced",8'h80, 0, 0, 3'b001, 1, 32'h5004);
    step("R8 ibus beats host", 8'h84, 0, 1, 3'b001, 0, 32'h5008);
    step("R8 brk beats all",   8'hBE, 1, 1, 3'b001, 0, 32'h500C);
    step("R8 watch vs dbus",   8'h18, 0, 0, 3'b001, 0, 32'h5010);
    step("R8 irq vs scall",    8'h80, 1, 0, 3'b001, 0, 32'h5014);
    step("R9 hold after idle", 8'h00, 0, 1, 3'b111, 1, 32'h5018);

    for (int i = 0; i < 400; i++) begin
      logic [7:0] c = 8'h00;
      if ($urandom_range(0, 2) == 0) c = 8'($urandom);
      else if ($urandom_range(0, 1) == 0) c = 8'(1 << $urandom_range(0, 7));
      step("R8 random", c, 1'($urandom), 1'($urandom), 3'($urandom),
           1'($urandom), {$urandom} & 32'hFFFF_FFFC);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule